// File: doc/BRIEF.md
# Serial Majority-Vote Codeword Corrector with Early Clean-Word Exit

This block repairs a 15-bit codeword of a cyclic (15,7) double-error-correcting code after it has been read back from storage. The word is loaded into a circular register. On every step, four parity sums are taken over fixed register positions. All four sums include the top position. When a majority of the sums are set, the top bit is inverted as it wraps round to the bottom. Fifteen steps bring every bit through the top once, and the register ends back in its original alignment.

Most words read from storage are clean, so a short watch runs alongside the rotation. The OR of the sums from the first three steps is collected. If every sum stayed zero, the run stops after three steps and returns the input word, rotated back into alignment. If any sum was set, the error flag is raised and the full fifteen-step correction completes. A caller pulses a start request together with the word, waits for the one-cycle completion pulse, and then reads the data and error flag. Both stay valid until the next run produces new results.

Top module: `mld_early_exit`

## Requirements
- R1: While reset is asserted and right after it, busy_o, done_o and err_o are 0 and data_o is all zeros.
- R2: A start_i seen at a rising edge while busy_o is 0 is accepted. busy_o is 1 after that edge.
- R3: Codeword bit i is the coefficient of x^i. Bits 14..8 hold the message and bits 7..0 hold the remainder of x^8·m(x) divided by g(x)=1+x^4+x^6+x^7+x^8. For such a valid word, done_o rises 3 clock edges after the accepting edge, err_o is 0 and data_o equals the input word.
- R4: A valid word with exactly one inverted bit, at any position, is repaired. done_o rises 15 edges after the accepting edge, err_o is 1 and data_o equals the valid word.
- R5: A valid word with two inverted bits, at any two distinct positions, is repaired in 15 edges with err_o equal to 1.
- R6: done_o is high for exactly one cycle. busy_o falls in that same cycle and at no other time.
- R7: A start_i raised while busy_o is 1 is ignored. The run in progress keeps its timing and its result.
- R8: data_o changes only in a cycle where done_o is 1. err_o does not change while the block is idle, so both hold their values after a run until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to decode codeword_i |
| codeword_i | input | 15 | Word read from storage |
| data_o | output | 15 | Corrected, aligned codeword |
| err_o | output | 1 | A check fired during the first three steps |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when data_o is updated |

## Verification
A wrong position in a sum mask has two visible effects. Clean words start raising err_o and take 15 cycles instead of 3, or else single and double errors pass through uncorrected. Both show up at the first completion pulse of an affected word. A wrong step count or a misaligned register shows up as a rotated data_o at the very first run on either path. A detection history that is shifted or cleared badly misses the error pairs that only become visible on the second or third step. Directed words place errors at exactly those pairs.

// File: rtl/mld_early_exit.sv
module mld_early_exit #(
  parameter int N             = 15,
  parameter int NUM_CHECKS    = 4,
  parameter int DETECT_CYCLES = 3,
  parameter logic [NUM_CHECKS*N-1:0] CHECK_MASKS =
    {15'h4580, 15'h5808, 15'h6022, 15'h4045}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N-1:0] codeword_i,
  output logic [N-1:0] data_o,
  output logic         err_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int CW       = $clog2(N + 1);
  localparam int HW       = DETECT_CYCLES - 1;
  localparam int VOTE_MIN = NUM_CHECKS / 2 + 1;

  logic [N-1:0]          word_q, data_q;
  logic [CW-1:0]         step_q;
  logic [HW-1:0]         hist_q;
  logic                  busy_q, done_q, err_q;
  logic [NUM_CHECKS-1:0] sums;
  logic                  flip, any_now, seen;
  logic [N-1:0]          rotated, realigned;
  logic [2*N-1:0]        doubled;

  for (genvar g = 0; g < NUM_CHECKS; g++) begin : g_sum
    assign sums[g] = ^(word_q & CHECK_MASKS[g*N +: N]);
  end

  assign flip      = $countones(sums) >= VOTE_MIN;
  assign any_now   = |sums;
  assign seen      = any_now | (|hist_q);
  assign rotated   = {word_q[N-2:0], word_q[N-1] ^ flip};
  assign doubled   = {word_q, word_q};
  assign realigned = doubled[HW +: N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      data_q <= '0;
      step_q <= '0;
      hist_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        word_q <= codeword_i;
        busy_q <= 1'b1;
        step_q <= '0;
        hist_q <= '0;
        err_q  <= 1'b0;
      end else if (busy_q) begin
        word_q <= rotated;
        step_q <= step_q + 1'b1;
        hist_q <= (hist_q << 1) | HW'(any_now);
        if (step_q == CW'(HW)) begin
          err_q <= seen;
          if (!seen) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            data_q <= realigned;
          end
        end
        if (step_q == CW'(N - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          data_q <= rotated;
        end
      end
    end
  end

  assign data_o = data_q;
  assign err_o  = err_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  logic [CW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  a_r3_early_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> run_len == CW'(DETECT_CYCLES));
  a_r4_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> run_len == CW'(N));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(data_o));
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(err_o));
endmodule

// File: tb/test_mld_early_exit.sv
`timescale 1ns/1ps
module test_mld_early_exit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] codeword_i = '0;
  logic [14:0] data_o;
  logic        err_o, busy_o, done_o;
  int          n_checks = 0;
  int          n_fails = 0;

  always #2 clk = ~clk;

  mld_early_exit i_mld_early_exit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .codeword_i(codeword_i),
    .data_o(data_o), .err_o(err_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [14:0] enc(input logic [6:0] m);
    logic [14:0] r;
    r = {m, 8'b0};
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'(9'b111010001) << (i - 8));
    return {m, r[7:0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one word; optionally raises a second start mid-run (R7).
  task automatic run(input logic [6:0] msg, input logic [14:0] flips,
                     input string req, input bit intrude);
    logic [14:0] good;
    int n;
    good = enc(msg);
    @(negedge clk);
    start_i = 1'b1;
    codeword_i = good ^ flips;
    @(negedge clk);
    start_i = 1'b0;
    check(req, "busy after start (R2)", 32'(busy_o), 32'd1);
    n = 0;
    while (!done_o && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (intrude && n == 4) begin start_i = 1'b1; codeword_i = ~codeword_i; end
      if (intrude && n == 5) start_i = 1'b0;
      if (done_o) check(req, "busy low at done (R6)", 32'(busy_o), 32'd0);
    end
    check(req, "cycles", 32'(n), (flips == 0) ? 32'd3 : 32'd15);
    check(req, "data", 32'(data_o), 32'(good));
    check(req, "err", 32'(err_o), 32'(flips != 0));
    @(negedge clk);
    check(req, "done one cycle (R6)", 32'(done_o), 32'd0);
  endtask

  localparam logic [21:0] VEC [12] = '{
    {7'h00, 15'h0000}, {7'h7F, 15'h0000}, {7'h55, 15'h0000},
    {7'h2A, 15'h4000}, {7'h13, 15'h0001}, {7'h64, 15'h0010},
    {7'h39, 15'h0210}, {7'h5A, 15'h0022}, {7'h0F, 15'h0005},
    {7'h70, 15'h6000}, {7'h01, 15'h0080}, {7'h3C, 15'h1008}
  };

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 32'(busy_o), 32'd0);
    check("R1", "done in reset", 32'(done_o), 32'd0);
    check("R1", "err in reset", 32'(err_o), 32'd0);
    check("R1", "data in reset", 32'(data_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", 32'(busy_o), 32'd0);

    foreach (VEC[k]) begin
      int w;
      w = $countones(VEC[k][14:0]);
      run(VEC[k][21:15], VEC[k][14:0], (w == 0) ? "R3" : (w == 1) ? "R4" : "R5", 1'b0);
    end

    for (int k = 0; k < 60; k++) begin
      int p1, p2, kind;
      logic [14:0] f;
      p1 = $urandom % 15;
      p2 = (p1 + 1 + $urandom % 14) % 15;
      kind = k % 3;
      f = '0;
      if (kind >= 1) f[p1] = 1'b1;
      if (kind == 2) f[p2] = 1'b1;
      run(7'($urandom), f, (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5", 1'b0);
    end

    run(7'h46, 15'h0100, "R7", 1'b1);
    run(7'h19, 15'h0408, "R7", 1'b1);

    repeat (5) @(negedge clk);
    check("R8", "err held while idle", 32'(err_o), 32'd1);
    check("R8", "data held while idle", 32'(data_o), 32'(enc(7'h19)));
    run(7'h22, 15'h0000, "R8", 1'b0);
    repeat (4) @(negedge clk);
    check("R8", "clean result held", 32'(data_o), 32'(enc(7'h22)));
    check("R8", "err stays clear", 32'(err_o), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule